// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block decides whether a timekeeping chip runs from its main supply or from its backup cell. It does not measure voltages. It receives four comparator results and a low-power control bit, and from these it holds a single mode bit. The mode bit shuts the serial host port while the chip is on backup, and other logic can use it to gate outputs.

Each comparator result passes through a two-flop synchroniser and then through a stability filter before it can affect the mode. The rules for leaving main mode and returning to it are not symmetric. Entering backup needs the main supply to be below the battery level minus hysteresis, and also below the trip level. In low-power mode only the battery comparison is used. Leaving backup needs either the main supply above the battery level plus hysteresis, or the main supply above the trip level plus hysteresis. Backup is blocked until the main supply has been seen at least once since reset or since a cold start.

The block also keeps two sticky flags. The battery flag records that backup was entered. The power-fail flag records a start after both supplies were lost.

Top module: `supply_switchover`

## Requirements
- R1: With `low_power` low, the controller moves from main mode to backup only when both `cmp_below_bat` and `cmp_below_trip` hold after filtering. The mode output changes 5 clock edges after the comparators change, so the entry edge is 5 edges after the second of the two comparators changes. Either comparator alone never causes entry.
- R2: In backup, the controller returns to main mode when `cmp_above_bat` or `cmp_above_trip` holds after filtering. Either one is sufficient, and the mode changes 5 edges after the comparator changes.
- R3: With `low_power` high, `cmp_below_trip` is ignored and entry needs only `cmp_below_bat`. `low_power` is not filtered, so it acts on the next edge.
- R4: Backup is entered only after a filtered `cmp_above_bat` or `cmp_above_trip` has been seen since reset or since the last `cold_start`. A `cold_start` forces main mode and removes that permission.
- R5: `bat_flag` is set on the edge that enters backup. A host status write (`status_wr`) with `status_wr_bat` = 0 clears it, and with `status_wr_bat` = 1 leaves it unchanged. If entry and a clear fall on the same edge, the flag is set.
- R6: `pfail_flag` is set one edge after a `cold_start` pulse and cleared one edge after `time_wr`. If both happen on the same edge, the flag is set. Entering backup does not touch it.
- R7: A completed status read (`status_rd_done`) clears `bat_flag` when `auto_clear` is high and has no effect when `auto_clear` is low.
- R8: `serial_en` is low exactly while `backup_mode` is high.
- R9: A comparator change reaches the mode logic only after the synchronised value has held for 2 consecutive cycles. A comparator pulse of one cycle has no effect.
- R10: While `rst_n` is low, the outputs are main mode, `serial_en` = 1, and both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_below_bat | input | 1 | Main supply below battery minus hysteresis (asynchronous) |
| cmp_above_bat | input | 1 | Main supply above battery plus hysteresis (asynchronous) |
| cmp_below_trip | input | 1 | Main supply below trip level (asynchronous) |
| cmp_above_trip | input | 1 | Main supply above trip level plus hysteresis (asynchronous) |
| low_power | input | 1 | Drop the trip-level check on entry |
| cold_start | input | 1 | One-cycle pulse: block restarting after loss of both supplies |
| status_wr | input | 1 | Host write strobe to the status byte |
| status_wr_bat | input | 1 | Written value of the battery flag bit; only 0 has an effect |
| status_rd_done | input | 1 | Host completed a read of the status byte |
| auto_clear | input | 1 | Clear the battery flag on a completed status read |
| time_wr | input | 1 | Host wrote a byte of the time section |
| backup_mode | output | 1 | 1 while running from the backup cell |
| serial_en | output | 1 | Serial host port enable; low in backup |
| bat_flag | output | 1 | Sticky flag: backup was entered |
| pfail_flag | output | 1 | Sticky flag: start after loss of both supplies |

## Verification
A comparator change that the bench drives just after a falling edge reaches the mode output on the fifth rising edge after it. That count is two synchroniser flops, two filter cycles and the mode register. A change to `low_power` and every host strobe show up on the first rising edge. The driver queues each expected output word with the exact cycle in which it is due. The monitor compares only on the falling edge of that cycle. For each mode change it also checks the cycle one edge earlier and expects no change yet, so a latency that is one cycle too short or too long fails.

// File: rtl/swo_pkg.sv
package swo_pkg;

  typedef enum logic {
    MODE_MAIN   = 1'b0,
    MODE_BACKUP = 1'b1
  } mode_e;

  // comparator bundle, MSB first
  typedef struct packed {
    logic below_bat;
    logic above_bat;
    logic below_trip;
    logic above_trip;
  } cmp_t;

  localparam int CMP_W = $bits(cmp_t);

  // entry needs the battery comparison, plus the trip comparison unless low power
  function automatic logic enter_ok(cmp_t c, logic lp);
    return c.below_bat && (lp || c.below_trip);
  endfunction

  // leaving backup needs either upper comparison
  function automatic logic leave_ok(cmp_t c);
    return c.above_bat || c.above_trip;
  endfunction

  // main supply counts as present when it clears either upper threshold
  function automatic logic main_seen(cmp_t c);
    return leave_ok(c);
  endfunction

endpackage

// File: rtl/swo_filter.sv
module swo_filter #(
  parameter int W             = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] filt_o
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYCLES - 1);

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic [SYNC_STAGES-1:0] sh;
    logic [CW-1:0]          cnt;
    logic                   f;
    logic                   s_last;

    assign s_last = sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh <= '0;
      end else begin
        sh <= {sh[SYNC_STAGES-2:0], din[gi]};
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        f   <= 1'b0;
      end else if (s_last == f) begin
        cnt <= '0;
      end else if (cnt == CNT_LAST) begin
        cnt <= '0;
        f   <= s_last;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

    assign sync_o[gi] = s_last;
    assign filt_o[gi] = f;
  end

endmodule

// File: rtl/swo_mode_fsm.sv
module swo_mode_fsm
  import swo_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  cmp_t  filt,
  input  logic  low_power,
  input  logic  cold_start,
  output mode_e mode,
  output logic  armed,
  output logic  enter_evt
);
  logic leave_evt;

  always_comb begin
    enter_evt = (mode == MODE_MAIN) && armed && !cold_start && enter_ok(filt, low_power);
    leave_evt = (mode == MODE_BACKUP) && !cold_start && leave_ok(filt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= MODE_MAIN;
      armed <= 1'b0;
    end else if (cold_start) begin
      mode  <= MODE_MAIN;
      armed <= 1'b0;
    end else begin
      if (enter_evt)      mode <= MODE_BACKUP;
      else if (leave_evt) mode <= MODE_MAIN;
      if (main_seen(filt)) armed <= 1'b1;
    end
  end

endmodule

// File: rtl/swo_flags.sv
module swo_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_evt,
  input  logic status_wr,
  input  logic status_wr_bat,
  input  logic status_rd_done,
  input  logic auto_clear,
  input  logic cold_start,
  input  logic time_wr,
  output logic bat_flag,
  output logic pfail_flag
);
  logic bat_clr;

  assign bat_clr = (status_wr && !status_wr_bat) || (status_rd_done && auto_clear);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bat_flag <= 1'b0;
    end else if (enter_evt) begin
      bat_flag <= 1'b1;
    end else if (bat_clr) begin
      bat_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfail_flag <= 1'b0;
    end else if (cold_start) begin
      pfail_flag <= 1'b1;
    end else if (time_wr) begin
      pfail_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/supply_switchover.sv
module supply_switchover
  import swo_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_below_bat,
  input  logic cmp_above_bat,
  input  logic cmp_below_trip,
  input  logic cmp_above_trip,
  input  logic low_power,
  input  logic cold_start,
  input  logic status_wr,
  input  logic status_wr_bat,
  input  logic status_rd_done,
  input  logic auto_clear,
  input  logic time_wr,
  output logic backup_mode,
  output logic serial_en,
  output logic bat_flag,
  output logic pfail_flag
);
  cmp_t  raw_w;
  cmp_t  filt_w;
  logic [CMP_W-1:0] sync_w;
  logic [CMP_W-1:0] filt_bits;
  mode_e mode_w;
  logic  armed_w;
  logic  enter_w;

  assign raw_w.below_bat  = cmp_below_bat;
  assign raw_w.above_bat  = cmp_above_bat;
  assign raw_w.below_trip = cmp_below_trip;
  assign raw_w.above_trip = cmp_above_trip;

  swo_filter #(
    .W             (CMP_W),
    .SYNC_STAGES   (SYNC_STAGES),
    .STABLE_CYCLES (STABLE_CYCLES)
  ) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (raw_w),
    .sync_o (sync_w),
    .filt_o (filt_bits)
  );

  assign filt_w = cmp_t'(filt_bits);

  swo_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .filt       (filt_w),
    .low_power  (low_power),
    .cold_start (cold_start),
    .mode       (mode_w),
    .armed      (armed_w),
    .enter_evt  (enter_w)
  );

  swo_flags u_flags (
    .clk            (clk),
    .rst_n          (rst_n),
    .enter_evt      (enter_w),
    .status_wr      (status_wr),
    .status_wr_bat  (status_wr_bat),
    .status_rd_done (status_rd_done),
    .auto_clear     (auto_clear),
    .cold_start     (cold_start),
    .time_wr        (time_wr),
    .bat_flag       (bat_flag),
    .pfail_flag     (pfail_flag)
  );

  assign backup_mode = (mode_w == MODE_BACKUP);
  assign serial_en   = (mode_w == MODE_MAIN);

endmodule

// File: rtl/swo_chk.sv
module swo_chk
  import swo_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CMP_W-1:0] sync_v,
  input logic [CMP_W-1:0] filt_v,
  input logic             armed,
  input logic             low_power,
  input logic             cold_start,
  input logic             backup_mode,
  input logic             serial_en,
  input logic             bat_flag,
  input logic             pfail_flag
);
  cmp_t f;
  assign f = cmp_t'(filt_v);

  p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!backup_mode && armed && !cold_start && f.below_bat && f.below_trip) |=> backup_mode);

  p_leave_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (backup_mode && !cold_start && (f.above_bat || f.above_trip)) |=> !backup_mode);

  p_lowpwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!backup_mode && armed && !cold_start && low_power && f.below_bat) |=> backup_mode);

  p_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!backup_mode && !armed) |=> !backup_mode);

  p_cold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cold_start |=> (!backup_mode && !armed));

  p_batset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backup_mode) |-> bat_flag);

  p_pfail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cold_start |=> pfail_flag);

  p_serial_r8: assert property (@(posedge clk) disable iff (!rst_n)
    backup_mode |-> !serial_en);

  p_filter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_v != $past(filt_v)) |->
      (((($past(sync_v) ^ filt_v) | ($past(sync_v, 2) ^ filt_v)) & (filt_v ^ $past(filt_v))) == '0));

endmodule

bind supply_switchover swo_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_v      (sync_w),
  .filt_v      (filt_bits),
  .armed       (armed_w),
  .low_power   (low_power),
  .cold_start  (cold_start),
  .backup_mode (backup_mode),
  .serial_en   (serial_en),
  .bat_flag    (bat_flag),
  .pfail_flag  (pfail_flag)
);

// File: tb/supply_switchover_test.sv
module supply_switchover_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_bb = 1'b1, c_ab = 1'b0, c_bt = 1'b1, c_at = 1'b0;
  logic low_power = 1'b0, cold_start = 1'b0;
  logic status_wr = 1'b0, status_wr_bat = 1'b0, status_rd_done = 1'b0;
  logic auto_clear = 1'b0, time_wr = 1'b0;
  logic backup_mode, serial_en, bat_flag, pfail_flag;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    int       due;
    logic [3:0] exp;
    string    tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  supply_switchover uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmp_below_bat  (c_bb),
    .cmp_above_bat  (c_ab),
    .cmp_below_trip (c_bt),
    .cmp_above_trip (c_at),
    .low_power      (low_power),
    .cold_start     (cold_start),
    .status_wr      (status_wr),
    .status_wr_bat  (status_wr_bat),
    .status_rd_done (status_rd_done),
    .auto_clear     (auto_clear),
    .time_wr        (time_wr),
    .backup_mode    (backup_mode),
    .serial_en      (serial_en),
    .bat_flag       (bat_flag),
    .pfail_flag     (pfail_flag)
  );

  // expected word {backup, serial_en, bat_flag, pfail_flag}; serial_en is low in backup (R8)
  function automatic logic [3:0] ev(logic b, logic bat, logic pf);
    return {b, ~b, bat, pf};
  endfunction

  task automatic expect_in(int d, logic [3:0] e, string t);
    item_t it;
    it.due = cyc + d;
    it.exp = e;
    it.tag = t;
    q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmp(logic bb, logic ab, logic bt, logic at);
    c_bb = bb; c_ab = ab; c_bt = bt; c_at = at;
  endtask

  // monitor: compare every queued item whose cycle has come
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        total++;
        if ({backup_mode, serial_en, bat_flag, pfail_flag} !== q[i].exp) begin
          bad++;
          $display("FAIL %s: got %b expected %b (cycle %0d)", q[i].tag,
                   {backup_mode, serial_en, bat_flag, pfail_flag}, q[i].exp, cyc);
        end
        q.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(4);
    expect_in(0, ev(0, 0, 0), "R10 reset state");
    step(1);
    rst_n = 1'b1;
    // main never present: entry conditions hold but block is not armed
    step(8);
    expect_in(1, ev(0, 0, 0), "R4 no backup before main seen");
    step(2);
    // main supply appears
    set_cmp(0, 1, 0, 1);
    step(10);
    // main drops below both levels
    set_cmp(1, 0, 1, 0);
    expect_in(4, ev(0, 0, 0), "R9 R1 not yet at edge 4");
    expect_in(5, ev(1, 1, 0), "R1 R5 R8 entry at edge 5");
    step(8);
    // return through trip comparison only
    set_cmp(1, 0, 0, 1);
    expect_in(4, ev(1, 1, 0), "R9 R2 not yet at edge 4");
    expect_in(5, ev(0, 1, 0), "R2 exit on trip level");
    step(8);
    // host write of 1 leaves flag, write of 0 clears
    status_wr = 1'b1; status_wr_bat = 1'b1;
    expect_in(1, ev(0, 1, 0), "R5 write of one has no effect");
    step(1);
    status_wr_bat = 1'b0;
    expect_in(1, ev(0, 0, 0), "R5 write of zero clears");
    step(1);
    status_wr = 1'b0;
    step(2);
    // only battery comparison true, trip not: no entry
    set_cmp(1, 0, 0, 0);
    step(8);
    expect_in(1, ev(0, 0, 0), "R1 battery condition alone no entry");
    step(2);
    // low power drops trip check
    low_power = 1'b1;
    expect_in(1, ev(1, 1, 0), "R3 low power entry");
    step(3);
    // exit through battery comparison only
    set_cmp(0, 1, 0, 0);
    expect_in(5, ev(0, 1, 0), "R2 exit on battery level");
    step(8);
    low_power = 1'b0;
    // single-cycle glitch
    set_cmp(1, 0, 1, 0);
    step(1);
    set_cmp(0, 1, 0, 0);
    expect_in(7, ev(0, 1, 0), "R9 one-cycle glitch rejected");
    step(9);
    // completed read without and with auto clear
    status_rd_done = 1'b1;
    expect_in(1, ev(0, 1, 0), "R7 read without auto clear keeps flag");
    step(1);
    auto_clear = 1'b1;
    expect_in(1, ev(0, 0, 0), "R7 read with auto clear clears flag");
    step(1);
    status_rd_done = 1'b0;
    auto_clear = 1'b0;
    step(2);
    // enter backup again
    set_cmp(1, 0, 1, 0);
    expect_in(5, ev(1, 1, 0), "R1 second entry, R6 pfail untouched");
    step(7);
    // cold start while main absent
    cold_start = 1'b1;
    expect_in(1, ev(0, 1, 1), "R6 R4 cold start sets pfail and forces main");
    step(1);
    cold_start = 1'b0;
    step(8);
    expect_in(1, ev(0, 1, 1), "R4 disarmed after cold start");
    step(2);
    // main returns, then time write clears pfail
    set_cmp(0, 1, 0, 1);
    step(8);
    time_wr = 1'b1;
    expect_in(1, ev(0, 1, 0), "R6 time write clears pfail");
    step(1);
    cold_start = 1'b1;
    expect_in(1, ev(0, 1, 1), "R6 set wins over clear");
    step(1);
    cold_start = 1'b0;
    time_wr = 1'b0;
    // re-arm after cold start, clear battery flag
    step(8);
    status_wr = 1'b1; status_wr_bat = 1'b0;
    expect_in(1, ev(0, 0, 1), "R5 clear before priority test");
    step(1);
    status_wr = 1'b0;
    step(2);
    // entry and clear on the same edge
    set_cmp(1, 0, 1, 0);
    step(4);
    status_wr = 1'b1; status_wr_bat = 1'b0;
    expect_in(1, ev(1, 1, 1), "R5 entry wins over clear");
    step(1);
    status_wr = 1'b0;
    step(3);
    total += q.size();
    bad += q.size();
    if (q.size() != 0) $display("FAIL scoreboard: got %0d pending expected 0", q.size());
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule